// File: doc/BRIEF.md
# Transfer Count and Activation Enable Controller

This block holds the counting and completion logic of a transfer engine that an interrupt source starts. It keeps two count registers, A and B, and a three-way mode select. Each accepted transfer pulse moves the counters. The block decides when the programmed sequence is finished, raises a one-cycle end-of-transfer or end-of-block pulse, and then clears the source's activation-enable bit. When it clears that bit it also raises a CPU interrupt request, which stays high until the CPU acknowledges it. Address generation and the data movement itself sit outside the block.

In normal mode, A is one full-width down-counter. In repeat and block modes, A splits into two bytes. The upper byte is a reload value and the lower byte is the running count. In block mode, B counts completed blocks. A control bit makes the enable clear after every single transfer instead of only at the end of the sequence. The CPU reaches every register through a small word-wide register port.

Top module: `xfer_count_ctrl`

## Requirements
- R1: After reset, both count registers, the mode (normal), the disable-after-transfer bit, the enable bit, the interrupt request, end_xfer and end_block are all 0.
- R2: Register port, with offset on reg_addr: 0 is count A, 1 is count B, 2 is control, 3 is enable. Control holds mode in bits 1:0 (0 normal, 1 repeat, 2 block) and disable-after-transfer in bit 2. Enable is bit 0. A read returns what was written. A write takes priority: a transfer pulse in the same cycle as any write is ignored.
- R3: In normal mode, each accepted pulse decrements A by 1. The pulse that takes A to 0 makes end_xfer high for exactly the next cycle. A loaded value of 0 gives 65536 transfers.
- R4: In repeat mode, the low byte of A decrements per accepted pulse. The pulse that takes it to 0 reloads it from the high byte, and the high byte never changes. end_xfer never rises, and with disable-after-transfer at 0 the enable stays set.
- R5: In block mode, the low byte of A decrements and reloads as in repeat mode, and a loaded low byte of 0 gives 256 transfers. Each reload makes end_block high for one cycle and decrements B. When B reaches 0 (a loaded 0 gives 65536 blocks), end_xfer pulses in the same cycle.
- R6: B does not change outside block mode, except by a register write.
- R7: With disable-after-transfer at 1, the enable bit is 0 in the cycle after every accepted pulse.
- R8: With disable-after-transfer at 0, the enable bit clears only in the cycle that end_xfer rises.
- R9: The interrupt request rises in the same cycle that a transfer clears the enable bit. It stays high until irq_ack. A new clear in the same cycle as irq_ack leaves it high.
- R10: A transfer pulse while the enable bit is 0 changes no counter and no output.
- R11: Mode code 3 behaves exactly like normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset for read and write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| xfer_pulse | input | 1 | One transfer unit completed |
| irq_ack | input | 1 | CPU acknowledge of the interrupt request |
| end_xfer | output | 1 | Sequence finished (one-cycle pulse) |
| end_block | output | 1 | Block finished in block mode (one-cycle pulse) |
| irq | output | 1 | CPU interrupt request, held until acknowledged |
| act_en | output | 1 | Activation-enable bit of the source |

## Verification
The assertions watch the local rules on every cycle:
- the interrupt rises with every transfer-driven clear of the enable and is held until acknowledged;
- disable-after-transfer clears the enable after each accepted pulse;
- a disabled source freezes both counters;
- B holds outside block mode;
- repeat mode never ends;
- end_xfer is a single-cycle pulse that coincides with a cleared enable.

Only the scenarios can show that the number of transfers is right: the 65536-count case for a loaded zero, the 256-unit low byte in block mode, the reload from the high byte, and the exact cycle of each end pulse.

// File: rtl/xcc_pkg.sv
package xcc_pkg;
    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_REPEAT = 2'd1,
        MODE_BLOCK  = 2'd2,
        MODE_RSVD   = 2'd3
    } xmode_e;

    localparam logic [1:0] ADDR_CNT_A = 2'd0;
    localparam logic [1:0] ADDR_CNT_B = 2'd1;
    localparam logic [1:0] ADDR_CTRL  = 2'd2;
    localparam logic [1:0] ADDR_EN    = 2'd3;
endpackage

// File: rtl/xcc_cnt_a.sv
module xcc_cnt_a import xcc_pkg::*; #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt,
    input  xmode_e           mode,
    input  logic             step,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             wrap,
    output logic             zero
);
    localparam int HALF = CNT_W / 2;

    logic             split;
    logic [HALF-1:0]  lo;
    logic [HALF-1:0]  hi;

    assign split = (mode == MODE_REPEAT) || (mode == MODE_BLOCK);
    assign lo    = cnt[HALF-1:0];
    assign hi    = cnt[CNT_W-1:HALF];

    always_comb begin
        cnt_nxt = cnt;
        wrap    = 1'b0;
        zero    = 1'b0;
        if (step) begin
            if (split) begin
                if (lo == HALF'(1)) begin
                    cnt_nxt = {hi, hi};
                    wrap    = 1'b1;
                end else begin
                    cnt_nxt = {hi, lo - HALF'(1)};
                end
            end else begin
                cnt_nxt = cnt - CNT_W'(1);
                zero    = (cnt == CNT_W'(1));
            end
        end
    end
endmodule

// File: rtl/xcc_cnt_b.sv
module xcc_cnt_b #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic             step,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             zero
);
    always_comb begin
        cnt_nxt = cnt;
        zero    = 1'b0;
        if (step) begin
            cnt_nxt = cnt - CNT_W'(1);
            zero    = (cnt == CNT_W'(1));
        end
    end
endmodule

// File: rtl/xcc_en_ctrl.sv
module xcc_en_ctrl (
    input  logic en_q,
    input  logic irq_q,
    input  logic accept,
    input  logic seq_done,
    input  logic dis,
    input  logic ack,
    input  logic en_wr,
    input  logic en_wdata,
    output logic en_d,
    output logic irq_d
);
    logic clr;

    assign clr = accept && (dis || seq_done);

    always_comb begin
        if (en_wr)    en_d = en_wdata;
        else if (clr) en_d = 1'b0;
        else          en_d = en_q;

        if (clr)      irq_d = 1'b1;
        else if (ack) irq_d = 1'b0;
        else          irq_d = irq_q;
    end
endmodule

// File: rtl/xfer_count_ctrl.sv
module xfer_count_ctrl import xcc_pkg::*; #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    input  logic             xfer_pulse,
    input  logic             irq_ack,
    output logic             end_xfer,
    output logic             end_block,
    output logic             irq,
    output logic             act_en
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt_a;
        logic [CNT_W-1:0] cnt_b;
        xmode_e           mode;
        logic             dis;
        logic             en;
        logic             irq;
        logic             end_x;
        logic             end_b;
    } state_t;

    state_t state_d, state_q;

    logic             accept;
    logic             blk;
    logic             a_wrap, a_zero, b_zero;
    logic [CNT_W-1:0] a_nxt, b_nxt;
    logic             seq_done;
    logic             en_d, irq_d;

    logic [CNT_W-1:0] cnt_a_q, cnt_b_q;
    logic [1:0]       mode_q;
    logic             dis_q;

    assign accept = xfer_pulse && state_q.en && !reg_wr;
    assign blk    = (state_q.mode == MODE_BLOCK);

    xcc_cnt_a #(.CNT_W(CNT_W)) u_cnt_a (
        .cnt     (state_q.cnt_a),
        .mode    (state_q.mode),
        .step    (accept),
        .cnt_nxt (a_nxt),
        .wrap    (a_wrap),
        .zero    (a_zero)
    );

    xcc_cnt_b #(.CNT_W(CNT_W)) u_cnt_b (
        .cnt     (state_q.cnt_b),
        .step    (accept && blk && a_wrap),
        .cnt_nxt (b_nxt),
        .zero    (b_zero)
    );

    assign seq_done = a_zero || (blk && a_wrap && b_zero);

    xcc_en_ctrl u_en (
        .en_q     (state_q.en),
        .irq_q    (state_q.irq),
        .accept   (accept),
        .seq_done (seq_done),
        .dis      (state_q.dis),
        .ack      (irq_ack),
        .en_wr    (reg_wr && (reg_addr == ADDR_EN)),
        .en_wdata (reg_wdata[0]),
        .en_d     (en_d),
        .irq_d    (irq_d)
    );

    always_comb begin
        state_d       = state_q;
        state_d.cnt_a = a_nxt;
        state_d.cnt_b = b_nxt;
        state_d.en    = en_d;
        state_d.irq   = irq_d;
        state_d.end_x = accept && seq_done;
        state_d.end_b = accept && blk && a_wrap;
        if (reg_wr) begin
            case (reg_addr)
                ADDR_CNT_A: state_d.cnt_a = reg_wdata;
                ADDR_CNT_B: state_d.cnt_b = reg_wdata;
                ADDR_CTRL: begin
                    state_d.mode = xmode_e'(reg_wdata[1:0]);
                    state_d.dis  = reg_wdata[2];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CNT_A: reg_rdata = state_q.cnt_a;
            ADDR_CNT_B: reg_rdata = state_q.cnt_b;
            ADDR_CTRL:  reg_rdata[2:0] = {state_q.dis, state_q.mode};
            default:    reg_rdata[0] = state_q.en;
        endcase
    end

    assign cnt_a_q   = state_q.cnt_a;
    assign cnt_b_q   = state_q.cnt_b;
    assign mode_q    = state_q.mode;
    assign dis_q     = state_q.dis;
    assign end_xfer  = state_q.end_x;
    assign end_block = state_q.end_b;
    assign irq       = state_q.irq;
    assign act_en    = state_q.en;
endmodule

// File: rtl/xcc_chk.sv
module xcc_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             xfer_pulse,
    input logic             reg_wr,
    input logic             irq_ack,
    input logic             act_en,
    input logic             irq,
    input logic             end_xfer,
    input logic             end_block,
    input logic [CNT_W-1:0] cnt_a,
    input logic [CNT_W-1:0] cnt_b,
    input logic [1:0]       mode,
    input logic             dis
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // R9: a clear not caused by a write raises the request
    p_irq_on_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(act_en) && !$past(reg_wr)) |-> irq);

    // R9: request held until acknowledged
    p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> irq);

    // R7
    p_dis_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (act_en && xfer_pulse && !reg_wr && dis) |=> (!act_en && irq));

    // R10
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_en && !reg_wr) |=> ($stable(cnt_a) && $stable(cnt_b)));

    // R6
    p_b_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd2 && !reg_wr) |=> $stable(cnt_b));

    // R4
    p_no_end_repeat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && !reg_wr) |=> !end_xfer);

    // R5
    p_end_block_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        end_block |-> ($past(mode) == 2'd2));

    // R8
    p_end_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        end_xfer |-> !act_en);

    // R3
    p_end_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        end_xfer |=> !end_xfer);

    // R3
    p_norm_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (act_en && xfer_pulse && !reg_wr && mode == 2'd0) |=> (cnt_a == $past(cnt_a) - ONE));
endmodule

bind xfer_count_ctrl xcc_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_pulse (xfer_pulse),
    .reg_wr     (reg_wr),
    .irq_ack    (irq_ack),
    .act_en     (act_en),
    .irq        (irq),
    .end_xfer   (end_xfer),
    .end_block  (end_block),
    .cnt_a      (cnt_a_q),
    .cnt_b      (cnt_b_q),
    .mode       (mode_q),
    .dis        (dis_q)
);

// File: tb/xfer_count_ctrl_test.sv
`timescale 1ns/1ps
module xfer_count_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        xfer_pulse = 1'b0;
    logic        irq_ack = 1'b0;
    logic        end_xfer, end_block, irq, act_en;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;
    bit done_flag = 0;

    // reference model state
    int ma = 0, mb = 0, mmode = 0, mdis = 0, men = 0, mirq = 0, mex = 0, meb = 0;

    always #10 clk = ~clk;

    xfer_count_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_pulse(xfer_pulse),
        .irq_ack(irq_ack), .end_xfer(end_xfer), .end_block(end_block),
        .irq(irq), .act_en(act_en)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int model_rd(input logic [1:0] a);
        case (a)
            2'd0: return ma;
            2'd1: return mb;
            2'd2: return mdis * 4 + mmode;
            default: return men;
        endcase
    endfunction

    // behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            ma = 0; mb = 0; mmode = 0; mdis = 0; men = 0; mirq = 0; mex = 0; meb = 0;
        end else begin
            mex = 0; meb = 0;
            if (irq_ack) mirq = 0;
            if (reg_wr) begin
                case (reg_addr)
                    2'd0: ma = int'(reg_wdata);
                    2'd1: mb = int'(reg_wdata);
                    2'd2: begin mmode = int'(reg_wdata[1:0]); mdis = int'(reg_wdata[2]); end
                    default: men = int'(reg_wdata[0]);
                endcase
            end else if (xfer_pulse && men == 1) begin
                int lo, hi;
                bit fin, wrapped;
                fin = 0; wrapped = 0;
                if (mmode == 1 || mmode == 2) begin
                    lo = ma % 256; hi = ma / 256;
                    if (lo == 1) begin lo = hi; wrapped = 1; end
                    else lo = (lo + 255) % 256;
                    ma = hi * 256 + lo;
                    if (mmode == 2 && wrapped) begin
                        meb = 1;
                        if (mb == 1) fin = 1;
                        mb = (mb + 65535) % 65536;
                    end
                end else begin
                    if (ma == 1) fin = 1;
                    ma = (ma + 65535) % 65536;
                end
                mex = fin;
                if (mdis == 1 || fin) begin men = 0; mirq = 1; end
            end
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            check("R2 rdata", 32'(reg_rdata), 32'(model_rd(reg_addr)));
            check("R8 act_en", 32'(act_en), 32'(men));
            check("R9 irq", 32'(irq), 32'(mirq));
            check("R3 end_xfer", 32'(end_xfer), 32'(mex));
            check("R5 end_block", 32'(end_block), 32'(meb));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done_flag) begin
            done_flag = 1;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic drive(input logic wr, input logic [1:0] a, input logic [15:0] d,
                         input logic p, input logic k);
        @(posedge clk); #2;
        reg_wr = wr; reg_addr = a; reg_wdata = d; xfer_pulse = p; irq_ack = k;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        drive(1'b1, a, d, 1'b0, 1'b0);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 2'd0, 16'd0, 1'b1, 1'b0);
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] a, input logic [15:0] exp);
        drive(1'b0, a, 16'd0, 1'b0, 1'b0);
        @(negedge clk);
        check(tag, 32'(reg_rdata), 32'(exp));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1 reset state
        rd_chk("R1 cnt A", 2'd0, 16'h0);
        rd_chk("R1 cnt B", 2'd1, 16'h0);
        rd_chk("R1 ctrl", 2'd2, 16'h0);
        rd_chk("R1 enable", 2'd3, 16'h0);
        check("R1 irq", 32'(irq), 32'd0);
        check("R1 end", 32'({end_xfer, end_block}), 32'd0);

        // R10 pulses while disabled
        wr(2'd0, 16'd5);
        pulses(3);
        rd_chk("R10 A unchanged", 2'd0, 16'd5);
        check("R10 no end", 32'(end_xfer), 32'd0);

        // R3/R8 normal mode, count 3
        wr(2'd0, 16'd3); wr(2'd1, 16'd9); wr(2'd2, 16'd0); wr(2'd3, 16'd1);
        pulses(2);
        rd_chk("R8 enable held", 2'd3, 16'd1);
        pulses(1);
        drive(1'b0, 2'd3, 16'd0, 1'b0, 1'b0);
        @(negedge clk);
        check("R3 end_xfer", 32'(end_xfer), 32'd1);
        check("R8 enable cleared", 32'(reg_rdata), 32'd0);
        check("R9 irq raised", 32'(irq), 32'd1);
        rd_chk("R3 A zero", 2'd0, 16'd0);
        rd_chk("R6 B untouched", 2'd1, 16'd9);
        drive(1'b0, 2'd0, 16'd0, 1'b0, 1'b1);
        drive(1'b0, 2'd0, 16'd0, 1'b0, 1'b0);
        @(negedge clk);
        check("R9 ack clears", 32'(irq), 32'd0);

        // R7 disable after every transfer
        wr(2'd0, 16'd10); wr(2'd2, 16'd4); wr(2'd3, 16'd1);
        pulses(1);
        rd_chk("R7 enable cleared", 2'd3, 16'd0);
        rd_chk("R7 A", 2'd0, 16'd9);
        // R9 set wins over ack
        wr(2'd3, 16'd1);
        drive(1'b0, 2'd0, 16'd0, 1'b1, 1'b1);
        drive(1'b0, 2'd0, 16'd0, 1'b0, 1'b0);
        @(negedge clk);
        check("R9 set over ack", 32'(irq), 32'd1);
        drive(1'b0, 2'd0, 16'd0, 1'b0, 1'b1);

        // R4 repeat mode
        wr(2'd0, 16'h0302); wr(2'd1, 16'd7); wr(2'd2, 16'd1); wr(2'd3, 16'd1);
        pulses(2);
        rd_chk("R4 reload", 2'd0, 16'h0303);
        pulses(7);
        rd_chk("R4 still enabled", 2'd3, 16'd1);
        rd_chk("R4 count", 2'd0, 16'h0302);
        rd_chk("R6 B held in repeat", 2'd1, 16'd7);

        // R5 block mode: 2 units x 3 blocks
        wr(2'd0, 16'h0202); wr(2'd1, 16'd3); wr(2'd2, 16'd2); wr(2'd3, 16'd1);
        pulses(2);
        rd_chk("R5 B after block", 2'd1, 16'd2);
        pulses(4);
        drive(1'b0, 2'd1, 16'd0, 1'b0, 1'b0);
        @(negedge clk);
        check("R5 end_xfer", 32'(end_xfer), 32'd1);
        check("R5 end_block", 32'(end_block), 32'd1);
        check("R5 B zero", 32'(reg_rdata), 32'd0);
        rd_chk("R5 enable cleared", 2'd3, 16'd0);
        drive(1'b0, 2'd0, 16'd0, 1'b0, 1'b1);

        // R5 low byte 0 means 256 units
        wr(2'd0, 16'h0000); wr(2'd1, 16'd1); wr(2'd3, 16'd1);
        pulses(255);
        rd_chk("R5 not yet done", 2'd3, 16'd1);
        pulses(1);
        rd_chk("R5 done at 256", 2'd3, 16'd0);
        drive(1'b0, 2'd0, 16'd0, 1'b0, 1'b1);

        // R11 mode code 3
        wr(2'd0, 16'd2); wr(2'd2, 16'd3); wr(2'd3, 16'd1);
        pulses(2);
        drive(1'b0, 2'd3, 16'd0, 1'b0, 1'b0);
        @(negedge clk);
        check("R11 end_xfer", 32'(end_xfer), 32'd1);
        check("R11 enable cleared", 32'(reg_rdata), 32'd0);
        drive(1'b0, 2'd0, 16'd0, 1'b0, 1'b1);

        // R2 write wins over pulse
        wr(2'd2, 16'd0); wr(2'd0, 16'd8); wr(2'd3, 16'd1);
        drive(1'b1, 2'd0, 16'd20, 1'b1, 1'b0);
        rd_chk("R2 write priority", 2'd0, 16'd20);
        rd_chk("R2 ctrl readback", 2'd2, 16'd0);

        // R3 loaded zero gives 65536 transfers
        wr(2'd0, 16'd0);
        pulses(65535);
        rd_chk("R3 still enabled", 2'd3, 16'd1);
        rd_chk("R3 A at one", 2'd0, 16'd1);
        pulses(1);
        drive(1'b0, 2'd0, 16'd0, 1'b0, 1'b0);
        @(negedge clk);
        check("R3 end at 65536", 32'(end_xfer), 32'd1);
        drive(1'b0, 2'd0, 16'd0, 1'b0, 1'b0);
        @(negedge clk);

        done_flag = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule